// File: doc/BRIEF.md
# Single-to-Half Precision Narrowing Converter

This block takes a 32-bit single-precision floating-point word and returns its 16-bit half-precision equivalent, rounded to nearest with ties going to the even neighbour. The result is 1 sign bit, a 5-bit exponent field with bias 15, and 10 stored fraction bits. Normal results carry an implicit leading 1, which gives 11 bits of precision. Results smaller than 2^-14 come out as subnormals with exponent field 0.

Each input word arrives on a valid/data pair. The result appears one clock later, together with three status bits for that word: overflow, underflow and inexact.

A mode pin picks one of two output formats:
- **Standard format.** Exponent field 31 is reserved for infinity and NaN.
- **Extended format.** Exponent field 31 is an ordinary binade, which reaches 131008. There is no encoding for infinity or NaN, so anything that does not fit is clamped to the largest magnitude.

Top module: `sp2hp_narrow`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous clock. An active-low reset clears `out_valid`. Result and flags are loaded only in cycles where `in_valid` is high.
- R2: Finite results round to nearest-even. Rounding uses the first discarded bit, the next bit and an OR of all lower discarded bits. The output is bit 15 = sign, bits 14:10 = exponent field, bits 9:0 = fraction (1.0 gives 0x3C00, 1/3 gives 0x3555).
- R3: When rounding carries out of the fraction, the exponent field goes up by one. For example, 2-2^-23 gives 0x4000, and 2^-14-2^-38 gives 0x0400.
- R4: Results below 2^-14 use exponent field 0 and are exact where possible. 2^-24 gives 0x0001, and 1023·2^-24 gives 0x03FF. `out_unf` is set when the value before rounding is below 2^-14 and bits were lost.
- R5: A non-zero magnitude of at most 2^-25 becomes a zero with the input's sign, and sets `out_unf` and `out_inx`. This includes single-precision subnormal inputs. An input of ±0 gives ±0 with no flags set.
- R6: In standard format, a finite input that rounds to 65520 or more gives 0x7C00 or 0xFC00 and sets `out_ovf` and `out_inx`. 65504 gives 0x7BFF exactly.
- R7: In standard format, an infinite input gives an infinity with the same sign and no flags.
- R8: In standard format, a NaN input gives exponent field 31 with the input's sign, fraction bit 9 forced to 1, and fraction bits 8:0 taken from input bits 21:13. No flags are set.
- R9: In extended format, exponent field 31 holds normal values: 65536 gives 0x7C00, and 131008 gives 0x7FFF. Both are exact.
- R10: In extended format, a finite input that rounds to 131072 or more gives a signed 0x7FFF with `out_ovf` and `out_inx` set. An infinity or NaN input gives the same clamped pattern and the same flags.
- R11: `out_inx` is set exactly when the result differs from the input value. `out_ovf` always comes with `out_inx`.
- R12: The output sign bit always equals the input sign bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid |
| in_data | input | 32 | Single-precision operand |
| alt_mode | input | 1 | 1 selects the extended format, 0 the standard format |
| out_valid | output | 1 | Result is valid |
| out_data | output | 16 | Half-precision result |
| out_ovf | output | 1 | Overflow for this result |
| out_unf | output | 1 | Underflow for this result |
| out_inx | output | 1 | Inexact for this result |

## Verification
The rounding patterns cover several discarded-bit cases, each expected to give a different result:
- discarded bits below half;
- an exact half with an even LSB;
- an exact half with an odd LSB;
- just over half.

Operands placed on either side of each threshold check which of the following bounds are set correctly:
- the 65504/65520 overflow edge;
- the subnormal/normal edge at 2^-14;
- the half-ulp zero edge at 2^-25.

The same operands are repeated in extended format, which shows which exponent-31 values are decoded as numbers and which are clamped. NaN payloads with different high fraction bits show whether the payload is carried through and whether the quiet bit is forced.

// File: rtl/sp2hp_pkg.sv
package sp2hp_pkg;
  localparam int SRC_EW  = 8;
  localparam int SRC_FW  = 23;
  localparam int DST_EW  = 5;
  localparam int DST_FW  = 10;
  localparam int SRC_W   = 1 + SRC_EW + SRC_FW;
  localparam int DST_W   = 1 + DST_EW + DST_FW;
  localparam int SRC_BIAS = (1 << (SRC_EW - 1)) - 1;
  localparam int DST_BIAS = (1 << (DST_EW - 1)) - 1;
  localparam int EXP_OFS  = SRC_BIAS - DST_BIAS;
  localparam int NORM_SH  = SRC_FW - DST_FW;
  localparam int MAX_SH   = SRC_FW + 3;
  localparam int HE_W     = SRC_EW + 2;
  localparam int SH_W     = $clog2(MAX_SH + 1);
  localparam int MAG_W    = HE_W + DST_FW;

  typedef enum logic [2:0] {
    K_ZERO, K_TINY, K_FIN, K_INF, K_NAN
  } kind_e;

  typedef struct packed {
    logic [DST_W-1:0] word;
    logic             ovf;
    logic             unf;
    logic             inx;
  } hres_t;
endpackage

// File: rtl/sp2hp_unpack.sv
module sp2hp_unpack
  import sp2hp_pkg::*;
(
  input  logic [SRC_W-1:0]      word,
  output kind_e                 kind,
  output logic                  sgn,
  output logic signed [HE_W-1:0] hexp,
  output logic [SRC_FW:0]       sig,
  output logic [DST_FW-2:0]     payload
);
  logic [SRC_EW-1:0] ef;
  logic [SRC_FW-1:0] ff;

  always_comb begin
    sgn     = word[SRC_W-1];
    ef      = word[SRC_W-2:SRC_FW];
    ff      = word[SRC_FW-1:0];
    hexp    = $signed({2'b00, ef}) - HE_W'(EXP_OFS);
    sig     = {1'b1, ff};
    payload = ff[SRC_FW-2 -: DST_FW-1];
    if (ef == '1)      kind = (ff == '0) ? K_INF : K_NAN;
    else if (ef == '0) kind = (ff == '0) ? K_ZERO : K_TINY;
    else               kind = K_FIN;
  end
endmodule

// File: rtl/sp2hp_round.sv
module sp2hp_round
  import sp2hp_pkg::*;
(
  input  logic                   sgn,
  input  logic signed [HE_W-1:0] hexp,
  input  logic [SRC_FW:0]        sig,
  input  logic                   alt,
  output hres_t                  res
);
  localparam int SX_W = MAX_SH;
  logic                   norm;
  logic signed [HE_W-1:0] sub;
  logic [SH_W-1:0]        sh, sh1;
  logic [SX_W-1:0]        sx, mask, q;
  logic                   g, st, up, lost, ovf;
  logic [HE_W-1:0]        ebase;
  logic [MAG_W-1:0]       mag, limit;

  always_comb begin
    norm = (hexp > 0);
    sub  = HE_W'(NORM_SH + 1) - hexp;
    if (norm)                      sh = SH_W'(NORM_SH);
    else if (sub > HE_W'(MAX_SH))  sh = SH_W'(MAX_SH);
    else                           sh = sub[SH_W-1:0];
    sh1   = sh - SH_W'(1);
    sx    = SX_W'(sig);
    q     = sx >> sh;
    g     = sx[sh1];
    mask  = (SX_W'(1) << sh1) - SX_W'(1);
    st    = |(sx & mask);
    up    = g & (st | q[0]);
    lost  = g | st;
    ebase = norm ? HE_W'(hexp - HE_W'(1)) : '0;
    mag   = {ebase, {DST_FW{1'b0}}} + MAG_W'(q[DST_FW:0]) + MAG_W'(up);
    limit = alt ? MAG_W'(32 << DST_FW) : MAG_W'(31 << DST_FW);
    ovf   = (mag >= limit);
    if (ovf)
      res.word = alt ? {sgn, {(DST_W-1){1'b1}}} : {sgn, {DST_EW{1'b1}}, {DST_FW{1'b0}}};
    else
      res.word = {sgn, mag[DST_W-2:0]};
    res.ovf = ovf;
    res.unf = !norm && lost;
    res.inx = lost || ovf;
  end
endmodule

// File: rtl/sp2hp_narrow.sv
module sp2hp_narrow
  import sp2hp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SRC_W-1:0]  in_data,
  input  logic              alt_mode,
  output logic              out_valid,
  output logic [DST_W-1:0]  out_data,
  output logic              out_ovf,
  output logic              out_unf,
  output logic              out_inx
);
  kind_e                  kind;
  logic                   sgn;
  logic signed [HE_W-1:0] hexp;
  logic [SRC_FW:0]        sig;
  logic [DST_FW-2:0]      payload;
  hres_t                  fin_res, nxt, cur;

  sp2hp_unpack u_unp (
    .word(in_data), .kind(kind), .sgn(sgn), .hexp(hexp), .sig(sig), .payload(payload)
  );

  sp2hp_round u_rnd (
    .sgn(sgn), .hexp(hexp), .sig(sig), .alt(alt_mode), .res(fin_res)
  );

  // next-state selection
  always_comb begin
    nxt = fin_res;
    unique case (kind)
      K_ZERO: nxt = '{word: {sgn, {(DST_W-1){1'b0}}}, ovf: 1'b0, unf: 1'b0, inx: 1'b0};
      K_TINY: nxt = '{word: {sgn, {(DST_W-1){1'b0}}}, ovf: 1'b0, unf: 1'b1, inx: 1'b1};
      K_INF, K_NAN: begin
        if (alt_mode)
          nxt = '{word: {sgn, {(DST_W-1){1'b1}}}, ovf: 1'b1, unf: 1'b0, inx: 1'b1};
        else if (kind == K_INF)
          nxt = '{word: {sgn, {DST_EW{1'b1}}, {DST_FW{1'b0}}}, ovf: 1'b0, unf: 1'b0, inx: 1'b0};
        else
          nxt = '{word: {sgn, {DST_EW{1'b1}}, 1'b1, payload}, ovf: 1'b0, unf: 1'b0, inx: 1'b0};
      end
      default: nxt = fin_res;
    endcase
  end

  // register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) cur <= nxt;
  end

  assign out_data = cur.word;
  assign out_ovf  = cur.ovf;
  assign out_unf  = cur.unf;
  assign out_inx  = cur.inx;

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid)));

  // R12
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[DST_W-1] == $past(in_data[SRC_W-1])));

  // R11
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> out_inx);

  // R4
  unf_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unf) |-> (out_data[DST_W-2:DST_FW] <= DST_EW'(1)));

  // R8
  nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(alt_mode) && ($past(in_data[SRC_W-2:SRC_FW]) == '1)
     && ($past(in_data[SRC_FW-1:0]) != '0))
    |-> (out_data[DST_FW-1] && (out_data[DST_W-2:DST_FW] == '1)));
endmodule

// File: tb/sim_sp2hp_narrow.sv
module sim_sp2hp_narrow;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic        alt_mode;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_ovf, out_unf, out_inx;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sp2hp_narrow u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .alt_mode(alt_mode), .out_valid(out_valid), .out_data(out_data),
    .out_ovf(out_ovf), .out_unf(out_unf), .out_inx(out_inx)
  );

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // flags = {ovf, unf, inx}
  task automatic conv(input string tag, input logic alt, input logic [31:0] x,
                      input logic [15:0] ew, input logic [2:0] ef);
    @(negedge clk);
    in_valid = 1'b1; in_data = x; alt_mode = alt;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {19'd0, out_valid}, 20'd1);
    check(tag, {1'b0, out_data, out_ovf, out_unf, out_inx}, {1'b0, ew, ef});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; alt_mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", {19'd0, out_valid}, 20'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", {19'd0, out_valid}, 20'd0);
  endtask

  task automatic t_round;
    conv("R2 one",        0, 32'h3F800000, 16'h3C00, 3'b000);
    conv("R2 third",      0, 32'h3EAAAAAB, 16'h3555, 3'b001);
    conv("R2 tie even",   0, 32'h3F801000, 16'h3C00, 3'b001);
    conv("R2 tie odd",    0, 32'h3F803000, 16'h3C02, 3'b001);
    conv("R2 over half",  0, 32'h3F801001, 16'h3C01, 3'b001);
    conv("R12 neg two",   0, 32'hC0000000, 16'hC000, 3'b000);
  endtask

  task automatic t_carry;
    conv("R3 to two",     0, 32'h3FFFFFFF, 16'h4000, 3'b001);
    conv("R3 sub to norm",0, 32'h387FFFFF, 16'h0400, 3'b011);
  endtask

  task automatic t_subnormal;
    conv("R4 min normal", 0, 32'h38800000, 16'h0400, 3'b000);
    conv("R4 min sub",    0, 32'h33800000, 16'h0001, 3'b000);
    conv("R4 max sub",    0, 32'h387FC000, 16'h03FF, 3'b000);
    conv("R4 above half ulp", 0, 32'h33000001, 16'h0001, 3'b011);
  endtask

  task automatic t_tiny;
    conv("R5 half ulp",   0, 32'h33000000, 16'h0000, 3'b011);
    conv("R5 neg half",   0, 32'hB3000000, 16'h8000, 3'b011);
    conv("R5 far tiny",   0, 32'h2EDBE6FF, 16'h0000, 3'b011);
    conv("R5 src sub",    0, 32'h80000001, 16'h8000, 3'b011);
    conv("R5 neg zero",   0, 32'h80000000, 16'h8000, 3'b000);
    conv("R11 pos zero",  0, 32'h00000000, 16'h0000, 3'b000);
  endtask

  task automatic t_std_ovf;
    conv("R6 max",        0, 32'h477FE000, 16'h7BFF, 3'b000);
    conv("R6 below edge", 0, 32'h477FEF00, 16'h7BFF, 3'b001);
    conv("R6 edge",       0, 32'h477FF000, 16'h7C00, 3'b101);
    conv("R6 neg edge",   0, 32'hC77FF000, 16'hFC00, 3'b101);
    conv("R6 huge",       0, 32'h501502F9, 16'h7C00, 3'b101);
  endtask

  task automatic t_specials;
    conv("R7 pos inf",    0, 32'h7F800000, 16'h7C00, 3'b000);
    conv("R7 neg inf",    0, 32'hFF800000, 16'hFC00, 3'b000);
    conv("R8 qnan",       0, 32'h7FC00000, 16'h7E00, 3'b000);
    conv("R8 snan",       0, 32'hFF800001, 16'hFE00, 3'b000);
    conv("R8 payload",    0, 32'h7FA00000, 16'h7F00, 3'b000);
  endtask

  task automatic t_alt;
    conv("R9 one",        1, 32'h3F800000, 16'h3C00, 3'b000);
    conv("R9 65536",      1, 32'h47800000, 16'h7C00, 3'b000);
    conv("R9 131008",     1, 32'h47FFE000, 16'h7FFF, 3'b000);
    conv("R9 65520",      1, 32'h477FF000, 16'h7C00, 3'b001);
    conv("R10 round sat", 1, 32'h47FFFF00, 16'h7FFF, 3'b101);
    conv("R10 neg huge",  1, 32'hD01502F9, 16'hFFFF, 3'b101);
    conv("R10 inf",       1, 32'h7F800000, 16'h7FFF, 3'b101);
    conv("R10 nan",       1, 32'hFFC00000, 16'hFFFF, 3'b101);
  endtask

  task automatic t_hold;
    conv("R1 load", 0, 32'h3F800000, 16'h3C00, 3'b000);
    @(negedge clk);
    in_valid = 1'b0; in_data = 32'h7F800000;
    @(negedge clk);
    check("R1 no valid", {19'd0, out_valid}, 20'd0);
    check("R1 held", {1'b0, out_data, out_ovf, out_unf, out_inx}, {1'b0, 16'h3C00, 3'b000});
  endtask

  initial begin
    t_reset;
    t_round;
    t_carry;
    t_subnormal;
    t_tiny;
    t_std_ovf;
    t_specials;
    t_alt;
    t_hold;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule